// File: doc/BRIEF.md
# CAN Transmit Timeout and Bus Wake Detector

This block is the digital control that sits between a CAN protocol controller and the analog parts of a CAN transceiver. When the mode controller enables it, the transmit-data input reaches the bus driver directly. A dominant-time limiter turns the driver off if transmit data stays dominant too long, and the driver stays off until transmit data has gone recessive again. The receive-data output then follows the synchronized bus level.

When the block is disabled, or while its reset is asserted, transmit data has no effect and receive data is parked recessive (high). In this state a pattern matcher watches the synchronized bus level for a wake sequence: a dominant phase, a recessive phase and a second dominant phase. Each phase must be held for a minimum filter time, and the whole sequence must fit inside a wake timeout. Once the sequence completes, the wake flag rises and receive data starts to follow the bus. Enabling the block again clears the wake flag and the matcher. All times are counted in clock cycles. The asynchronous bus level passes through a two-flop synchronizer before any timing is applied.

Top module: `can_txwake_ctrl`

## Requirements
- R1: While `rst_n` is low, `drv_dom` is 0, `rxd_out` is 1 and `wake_flag` is 0.
- R2: With `enable` at 1 and no timeout pending, `drv_dom` is 1 exactly when `txd_in` is 0 (dominant) and 0 when `txd_in` is 1, in the same cycle.
- R3: While `enable` is 1 and `txd_in` stays 0, `drv_dom` stays 1 until `DOM_TIMEOUT_CYC` rising edges have sampled `txd_in` low. It is 0 from that edge on.
- R4: After a timeout, `drv_dom` stays 0 for as long as `txd_in` stays 0. Once one rising edge has sampled `txd_in` at 1, a new 0 on `txd_in` drives `drv_dom` to 1 again.
- R5: With `enable` at 0, `drv_dom` is 0 for any `txd_in`, and `rxd_out` is 1 whatever the bus level, as long as `wake_flag` is 0.
- R6: `bus_lvl` 0 means dominant and 1 means recessive. With `enable` at 0, the following sequence raises `wake_flag` after `WAKE_FILT_CYC`+2 edges of the third phase and not earlier: dominant for at least `WAKE_FILT_CYC` edges, then recessive for at least `WAKE_FILT_CYC` edges, then dominant.
- R7: A phase shorter than `WAKE_FILT_CYC` samples does not advance the sequence. A level change inside a phase that is not yet qualified restarts that phase's count from zero; time is not accumulated across the interruption.
- R8: If the third phase has not qualified by the `WAKE_TO_CYC`-th synchronized sample (counted from the first dominant sample of the sequence), the sequence is dropped, no flag is raised, and a later full sequence is still detected.
- R9: While `wake_flag` is 1 and `enable` is 0, `rxd_out` follows `bus_lvl`.
- R10: The rising edge that samples `enable` at 1 clears `wake_flag`. While enabled, `rxd_out` follows `bus_lvl`. After a disable, `rxd_out` is parked at 1 again.
- R11: A sequence whose third phase qualifies on exactly the `WAKE_TO_CYC`-th sample is accepted. Completion takes priority over expiry of the wake timeout in the same cycle.
- R12: `bus_lvl` passes through two flops, so `rxd_out` shows a change of `bus_lvl` at the second rising edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Transceiver enable from the mode controller |
| txd_in | input | 1 | Transmit data, 0 = dominant |
| bus_lvl | input | 1 | Digitized bus level, asynchronous, 0 = dominant |
| drv_dom | output | 1 | Driver command, 1 = drive dominant |
| rxd_out | output | 1 | Receive data to the controller |
| wake_flag | output | 1 | Valid bus wake detected |

## Verification
The wake matcher can complete the third phase on the same sample on which its overall timeout expires. Both events are then due in the same cycle, and the design must choose completion. This case is provoked by making the recessive phase `WAKE_TO_CYC` − 2·`WAKE_FILT_CYC` edges long, so that the second dominant phase qualifies on the last allowed sample; the expected result is a raised flag. The same stimulus with the recessive phase one edge longer must give no flag. A property also checks that the completion and abort events are never active together.

// File: rtl/can_txw_pkg.sv
package can_txw_pkg;

  typedef enum logic [1:0] {
    PH_DOM_A = 2'd0,
    PH_REC   = 2'd1,
    PH_DOM_B = 2'd2
  } wake_phase_e;

  // Bits needed to hold the value lim
  function automatic int unsigned cnt_bits(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  // Increment that stops at lim
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // Level each wake phase expects: 1 = dominant
  function automatic logic phase_wants_dom(input wake_phase_e ph);
    return (ph != PH_REC);
  endfunction

  function automatic wake_phase_e phase_after(input wake_phase_e ph);
    case (ph)
      PH_DOM_A: return PH_REC;
      default:  return PH_DOM_B;
    endcase
  endfunction

endpackage

// File: rtl/can_lvl_sync.sv
module can_lvl_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/can_dom_limiter.sv
module can_dom_limiter import can_txw_pkg::*; #(
  parameter int unsigned TIMEOUT_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic txd_in,
  output logic drv_dom,
  output logic timeout_ev
);
  localparam int unsigned CW = cnt_bits(TIMEOUT_CYC);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          blocked_q;
  logic          wants_dom;

  assign wants_dom  = rst_n & enable & ~txd_in;
  assign drv_dom    = wants_dom & ~blocked_q;
  assign timeout_ev = drv_dom & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      blocked_q <= 1'b0;
    end else if (!wants_dom) begin
      cnt_q     <= '0;
      blocked_q <= 1'b0;
    end else if (timeout_ev) begin
      cnt_q     <= '0;
      blocked_q <= 1'b1;
    end else if (!blocked_q) begin
      cnt_q     <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/can_wake_matcher.sv
module can_wake_matcher import can_txw_pkg::*; #(
  parameter int unsigned FILT_CYC    = 400,
  parameter int unsigned TIMEOUT_CYC = 4000,
  parameter int unsigned TW          = cnt_bits(TIMEOUT_CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hunt,
  input  logic          bus_dom,
  output logic          woken,
  output logic          done_ev,
  output logic          abort_ev,
  output logic [TW-1:0] timer_q
);
  localparam int unsigned CW = cnt_bits(FILT_CYC);
  localparam logic [CW-1:0] FILT_V   = CW'(FILT_CYC);
  localparam logic [TW-1:0] TMR_LAST = TW'(TIMEOUT_CYC - 1);

  wake_phase_e   phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] tmr_d;
  logic          woken_q;
  logic          armed, lvl_ok, done_c, abort_c;

  assign armed  = (phase_q != PH_DOM_A) || (cnt_q != '0);
  assign lvl_ok = (bus_dom == phase_wants_dom(phase_q));

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    tmr_d   = timer_q;
    done_c  = 1'b0;
    abort_c = 1'b0;
    if (!armed) begin
      if (bus_dom) begin
        cnt_d = CW'(1);
        tmr_d = TW'(1);
      end
    end else begin
      if (lvl_ok)               cnt_d = CW'(sat_inc(32'(cnt_q), FILT_CYC));
      else if (cnt_q == FILT_V) begin
        phase_d = phase_after(phase_q);
        cnt_d   = CW'(1);
      end else                  cnt_d = '0;

      if (phase_d == PH_DOM_B && cnt_d == FILT_V) begin
        done_c  = 1'b1;
        phase_d = PH_DOM_A;
        cnt_d   = '0;
        tmr_d   = '0;
      end else if (phase_d == PH_DOM_A && cnt_d == '0) begin
        tmr_d   = '0;
      end else if (timer_q == TMR_LAST) begin
        abort_c = 1'b1;
        phase_d = PH_DOM_A;
        cnt_d   = '0;
        tmr_d   = '0;
      end else begin
        tmr_d   = timer_q + 1'b1;
      end
    end
  end

  assign done_ev  = done_c  & hunt & ~woken_q;
  assign abort_ev = abort_c & hunt & ~woken_q;
  assign woken    = woken_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_DOM_A;
      cnt_q   <= '0;
      timer_q <= '0;
      woken_q <= 1'b0;
    end else if (!hunt) begin
      phase_q <= PH_DOM_A;
      cnt_q   <= '0;
      timer_q <= '0;
      woken_q <= 1'b0;
    end else if (!woken_q) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      timer_q <= tmr_d;
      if (done_c) woken_q <= 1'b1;
    end
  end
endmodule

// File: rtl/can_txwake_ctrl.sv
module can_txwake_ctrl import can_txw_pkg::*; #(
  parameter int unsigned DOM_TIMEOUT_CYC = 2000,
  parameter int unsigned WAKE_FILT_CYC   = 400,
  parameter int unsigned WAKE_TO_CYC     = 4000,
  parameter int unsigned SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic txd_in,
  input  logic bus_lvl,
  output logic drv_dom,
  output logic rxd_out,
  output logic wake_flag
);
  localparam int unsigned TW = cnt_bits(WAKE_TO_CYC);

  // Named internal events, brought out for the checker
  logic          bus_lvl_s;
  logic          bus_dom_s;
  logic          tx_timeout_ev;
  logic          wake_done_ev;
  logic          wake_abort_ev;
  logic [TW-1:0] wake_timer;

  can_lvl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (bus_lvl),
    .q     (bus_lvl_s)
  );

  assign bus_dom_s = ~bus_lvl_s;

  can_dom_limiter #(.TIMEOUT_CYC(DOM_TIMEOUT_CYC)) u_lim (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .txd_in     (txd_in),
    .drv_dom    (drv_dom),
    .timeout_ev (tx_timeout_ev)
  );

  can_wake_matcher #(
    .FILT_CYC    (WAKE_FILT_CYC),
    .TIMEOUT_CYC (WAKE_TO_CYC),
    .TW          (TW)
  ) u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .hunt     (~enable),
    .bus_dom  (bus_dom_s),
    .woken    (wake_flag),
    .done_ev  (wake_done_ev),
    .abort_ev (wake_abort_ev),
    .timer_q  (wake_timer)
  );

  assign rxd_out = (enable | wake_flag) ? bus_lvl_s : 1'b1;
endmodule

// File: rtl/can_txwake_ctrl_chk.sv
module can_txwake_ctrl_chk #(
  parameter int unsigned TW          = 12,
  parameter int unsigned WAKE_TO_CYC = 4000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          txd_in,
  input logic          drv_dom,
  input logic          rxd_out,
  input logic          wake_flag,
  input logic          tx_timeout_ev,
  input logic          wake_done_ev,
  input logic          wake_abort_ev,
  input logic [TW-1:0] wake_timer
);
  localparam logic [TW-1:0] TO_V = TW'(WAKE_TO_CYC);

  // R3: a timeout leaves the driver recessive while txd stays dominant
  a_r3_block_after_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    tx_timeout_ev |=> (txd_in || !drv_dom));

  // R4: driving resumes only after txd was seen recessive
  a_r4_resume_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(drv_dom) && enable && $past(enable) && $past(rst_n)) |-> $past(txd_in));

  // R5: no drive while disabled
  a_r5_no_drive_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !drv_dom);

  // R5: receive data parked high before a wake
  a_r5_rxd_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !wake_flag) |-> rxd_out);

  // R6: a wake can only appear while hunting
  a_r6_wake_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> !$past(enable));

  // R10: enable clears the flag
  a_r10_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> !wake_flag);

  // R8: timer never reaches the window length
  a_r8_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wake_timer < TO_V);

  // R11: completion and expiry never reported together
  a_r11_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !(wake_done_ev && wake_abort_ev));
endmodule

bind can_txwake_ctrl can_txwake_ctrl_chk #(
  .TW          (TW),
  .WAKE_TO_CYC (WAKE_TO_CYC)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .enable        (enable),
  .txd_in        (txd_in),
  .drv_dom       (drv_dom),
  .rxd_out       (rxd_out),
  .wake_flag     (wake_flag),
  .tx_timeout_ev (tx_timeout_ev),
  .wake_done_ev  (wake_done_ev),
  .wake_abort_ev (wake_abort_ev),
  .wake_timer    (wake_timer)
);

// File: tb/can_txwake_ctrl_test.sv
`timescale 1ns/1ps
module can_txwake_ctrl_test;
  localparam int DTO  = 20;
  localparam int FILT = 6;
  localparam int WTO  = 60;

  logic clk = 1'b0;
  logic rst_n, enable, txd_in, bus_lvl;
  logic drv_dom, rxd_out, wake_flag;

  always #2.5 clk = ~clk;

  can_txwake_ctrl #(
    .DOM_TIMEOUT_CYC (DTO),
    .WAKE_FILT_CYC   (FILT),
    .WAKE_TO_CYC     (WTO)
  ) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .txd_in    (txd_in),
    .bus_lvl   (bus_lvl),
    .drv_dom   (drv_dom),
    .rxd_out   (rxd_out),
    .wake_flag (wake_flag)
  );

  // Scoreboard item: mask and expectation over {drv_dom, rxd_out, wake_flag}
  typedef struct {
    string      req;
    logic [2:0] m;
    logic [2:0] e;
  } sb_item_t;

  sb_item_t sb[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // Monitor
  initial begin
    forever begin
      sb_item_t it;
      logic [2:0] act;
      wait (sb.size() != 0);
      it  = sb.pop_front();
      act = {drv_dom, rxd_out, wake_flag};
      n_cmp++;
      if ((act & it.m) !== (it.e & it.m)) begin
        n_bad++;
        $display("FAIL %s: {drv,rxd,wake} actual %b expected %b (mask %b)",
                 it.req, act, it.e, it.m);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver side: push an expectation and wait until it is judged
  task automatic expect_out(input string req, input logic [2:0] m, input logic [2:0] e);
    sb_item_t it;
    #1;
    it.req = req; it.m = m; it.e = e;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic exp_drv(input string req, input logic v);  expect_out(req, 3'b100, {v, 2'b00}); endtask
  task automatic exp_rxd(input string req, input logic v);  expect_out(req, 3'b010, {1'b0, v, 1'b0}); endtask
  task automatic exp_wake(input string req, input logic v); expect_out(req, 3'b001, {2'b00, v}); endtask

  task automatic quiet();
    bus_lvl = 1'b1;
    tick(WTO + 5);
  endtask

  // First dominant a, recessive b, then leave bus dominant
  task automatic send(input int a, input int b);
    bus_lvl = 1'b0; tick(a);
    bus_lvl = 1'b1; tick(b);
    bus_lvl = 1'b0;
  endtask

  task automatic clear_wake();
    txd_in = 1'b1;
    enable = 1'b1; tick(1);
    enable = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enable = 1'b1; txd_in = 1'b1; bus_lvl = 1'b1;
    tick(4);
    expect_out("R1 reset state", 3'b111, 3'b010);
    txd_in = 1'b0;
    exp_drv("R1 txd ignored in reset", 1'b0);
    txd_in = 1'b1;
    rst_n = 1'b1;
    tick(3);

    // R2 pass-through
    exp_drv("R2 recessive txd", 1'b0);
    txd_in = 1'b0;
    exp_drv("R2 dominant txd", 1'b1);
    tick(1); txd_in = 1'b1;
    exp_drv("R2 back to recessive", 1'b0);

    // R12 synchronizer depth
    bus_lvl = 1'b0; tick(1);
    exp_rxd("R12 one edge", 1'b1);
    tick(1);
    exp_rxd("R12 two edges", 1'b0);
    bus_lvl = 1'b1; tick(2);
    exp_rxd("R12 return", 1'b1);

    // R3 dominant timeout
    txd_in = 1'b0; tick(DTO - 1);
    exp_drv("R3 before timeout", 1'b1);
    tick(1);
    exp_drv("R3 at timeout", 1'b0);
    tick(10);
    exp_drv("R4 blocked while low", 1'b0);
    txd_in = 1'b1; tick(1);
    exp_drv("R4 recessive", 1'b0);
    txd_in = 1'b0;
    exp_drv("R4 released", 1'b1);
    txd_in = 1'b1; tick(1);

    // R5 disabled
    enable = 1'b0; txd_in = 1'b0;
    exp_drv("R5 txd ignored", 1'b0);
    bus_lvl = 1'b0; tick(3);
    expect_out("R5 rxd parked", 3'b011, 3'b010);
    quiet();

    // R6 / R9 valid wake
    send(FILT, FILT);
    tick(FILT + 1);
    exp_wake("R6 one edge early", 1'b0);
    tick(1);
    expect_out("R6 wake raised", 3'b111, 3'b001);
    bus_lvl = 1'b1; tick(1);
    exp_rxd("R9 follow delay", 1'b0);
    tick(1);
    exp_rxd("R9 follows bus", 1'b1);

    // R10 enable clears
    txd_in = 1'b1; enable = 1'b1; tick(1);
    expect_out("R10 flag cleared", 3'b011, 3'b010);
    bus_lvl = 1'b0; tick(2);
    exp_rxd("R10 follows when enabled", 1'b0);
    bus_lvl = 1'b1; tick(2);
    enable = 1'b0; bus_lvl = 1'b0; tick(3);
    expect_out("R10 parked after disable", 3'b011, 3'b010);
    quiet();

    // R7 short phases and glitches
    send(FILT - 1, FILT); tick(FILT + 2);
    expect_out("R7 short first phase", 3'b011, 3'b010);
    quiet();
    send(FILT, FILT - 1); tick(FILT + 2);
    exp_wake("R7 short recessive phase", 1'b0);
    quiet();
    bus_lvl = 1'b0; tick(FILT);
    bus_lvl = 1'b1; tick(FILT - 2);
    bus_lvl = 1'b0; tick(1);
    bus_lvl = 1'b1; tick(2);
    bus_lvl = 1'b0; tick(FILT + 2);
    exp_wake("R7 glitch restarts phase", 1'b0);
    quiet();
    bus_lvl = 1'b0; tick(FILT);
    bus_lvl = 1'b1; tick(FILT - 2);
    bus_lvl = 1'b0; tick(1);
    bus_lvl = 1'b1; tick(FILT);
    bus_lvl = 1'b0; tick(FILT + 2);
    exp_wake("R7 requalified after glitch", 1'b1);
    clear_wake(); quiet();

    // R11 completion on the last allowed sample
    send(FILT, WTO - 2 * FILT); tick(FILT + 1);
    exp_wake("R11 not yet", 1'b0);
    tick(1);
    exp_wake("R11 completion wins", 1'b1);
    clear_wake(); quiet();

    // R8 one sample too late
    send(FILT, WTO - 2 * FILT + 1); tick(FILT + 2);
    expect_out("R8 timed out", 3'b011, 3'b010);
    tick(10);
    exp_wake("R8 stays idle", 1'b0);
    quiet();
    send(FILT, FILT); tick(FILT + 2);
    exp_wake("R8 detects again after drop", 1'b1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule